// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps one enable bit and one pending bit for each external interrupt vector of a small interrupt controller. Software reaches each kind of bit through a pair of aliased address windows. In one window, a 1 in the write data sets the bit. In the other window, a 1 clears it. A 0 leaves the bit alone in both. A read from either window of a pair returns the same live state. A third window shows, read-only, the active bits that the core drives in through `active_in`.

External vector numbering starts at 16. Index 0 of `irq_enable` and `irq_pending` is vector 16, index 1 is vector 17, and so on. A downstream priority arbiter consumes both vectors. Each time a write hits an enable or pending window, or pends a vector through the software trigger register at 0xF00, the bank raises `upd_strobe` for one cycle. This tells the arbiter to pick a new winner. Reads are combinational on the address and size. Writes take effect at the next rising clock edge.

Top module: `irq_state_bank`

## Requirements
- R1: While `rst_n` is low and right after reset, every enable and pending bit is 0 and `upd_strobe` is 0.
- R2: A write to byte addresses 0x100–0x13F sets the enable bit of each covered vector whose data bit is 1. Covered vectors with a 0 data bit keep their value.
- R3: Bit i of the data of an access at byte offset k inside a window maps to external index 8*k+i, which is vector 16+8*k+i. Bit 0 at the window base is vector 16.
- R4: A write to byte addresses 0x180–0x1BF clears the enable bit of each covered vector whose data bit is 1. A set through 0x100 followed by a clear of the same bit through 0x180 leaves that bit at 0.
- R5: Byte addresses 0x200–0x23F set pending bits and 0x280–0x2BF clear them, under the same 1-acts, 0-holds rule. A write to an enable window leaves pending unchanged, and a write to a pending window leaves enable unchanged.
- R6: A read of either window of a pair returns the live state bits, so a read of 0x100 and a read of 0x180 return the same word.
- R7: Byte addresses 0x300–0x37F read the `active_in` bits with the same mapping. Writes there change no state and raise no strobe.
- R8: `bus_size` gives the access size in bytes (1, 2 or 4). An access covers `bus_size`*8 bits, taken from the low bits of `bus_wdata` and returned in the low bits of `bus_rdata`. Higher read bits are 0 and higher write bits are ignored.
- R9: A bit that maps to an index at or above `NUM_VEC` reads as 0, and writes to it are ignored.
- R10: A 4-byte write to 0xF00 takes `bus_wdata[8:0]` as an external index. If that index is below `NUM_VEC`, the pending bit of that index is set. Otherwise nothing changes.
- R11: `upd_strobe` is high for exactly the one cycle after a write to any of the four enable or pending windows, or after an in-range trigger write. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` and `bus_size` |
| active_in | input | NUM_VEC | Active bits from the core, index 0 is vector 16 |
| irq_enable | output | NUM_VEC | Enable bits, index 0 is vector 16 |
| irq_pending | output | NUM_VEC | Pending bits, index 0 is vector 16 |
| upd_strobe | output | 1 | One-cycle pulse after a state-modifying write |

## Verification
The bench goes after the aliasing rules. It sets a bit through one window and clears it through the other. A design that decoded only one window of a pair, or returned a shadow copy, would leave the bit at 1 or read back different words. It pushes an all-ones word across the last partly implemented word and reads beyond it. Bits past `NUM_VEC` that read 1, or that disturbed neighbours, would show a wrong index base or a missing range check. Byte-sized accesses at odd offsets catch a mapping that uses the byte offset without scaling by eight. The bench also catches any size handling that lets upper data bits through. Writes to the active window and out-of-range trigger indices must leave state and the strobe untouched. A design that treated them as normal writes would pend or enable vectors, or pulse the arbiter for nothing.

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NUM_VEC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [2:0]         bus_size,
  input  logic               bus_we,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_VEC-1:0] active_in,
  output logic [NUM_VEC-1:0] irq_enable,
  output logic [NUM_VEC-1:0] irq_pending,
  output logic               upd_strobe
);
  localparam int          DW  = 32;
  localparam logic [10:0] NVW = 11'(NUM_VEC);
  localparam logic [11:0] TRIG_ADDR = 12'hF00;

  logic [NUM_VEC-1:0] en_q, pd_q, en_nx, pd_nx;
  logic               upd_q;

  // 64-byte blocks of the map
  wire [5:0] blk     = bus_addr[11:6];
  wire       win_es  = blk == 6'd4;
  wire       win_ec  = blk == 6'd6;
  wire       win_ps  = blk == 6'd8;
  wire       win_pc  = blk == 6'd10;
  wire       win_act = blk[5:1] == 5'd6;
  wire       hit_es  = bus_we && win_es;
  wire       hit_ec  = bus_we && win_ec;
  wire       hit_ps  = bus_we && win_ps;
  wire       hit_pc  = bus_we && win_pc;
  wire [5:0] nbits   = {bus_size, 3'b000};
  wire [9:0] off8    = win_act ? {bus_addr[6:0], 3'b000} : {1'b0, bus_addr[5:0], 3'b000};
  wire [8:0] trig_ix = bus_wdata[8:0];
  wire       trig_hit = bus_we && (bus_addr == TRIG_ADDR) && (bus_size == 3'd4)
                        && ({2'b00, trig_ix} < NVW);

  for (genvar j = 0; j < NUM_VEC; j++) begin : g_lane
    localparam logic [10:0] JV = 11'(j);
    wire [10:0] rel = JV - {1'b0, off8};
    wire        cov = (JV >= {1'b0, off8}) && (rel < {5'b0, nbits});
    wire        wb  = cov && bus_wdata[rel[4:0]];
    wire        tr  = trig_hit && ({2'b00, trig_ix} == JV);
    assign en_nx[j] = (hit_es && wb) ? 1'b1 : (hit_ec && wb) ? 1'b0 : en_q[j];
    assign pd_nx[j] = ((hit_ps && wb) || tr) ? 1'b1 : (hit_pc && wb) ? 1'b0 : pd_q[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pd_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      en_q  <= en_nx;
      pd_q  <= pd_nx;
      upd_q <= hit_es || hit_ec || hit_ps || hit_pc || trig_hit;
    end
  end

  wire [NUM_VEC-1:0] rd_src = win_act ? active_in :
                              (win_es || win_ec) ? en_q :
                              (win_ps || win_pc) ? pd_q : '0;

  for (genvar i = 0; i < DW; i++) begin : g_rd
    wire [10:0]        idx = {1'b0, off8} + 11'(i);
    wire               ok  = (6'(i) < nbits) && (idx < NVW);
    wire [NUM_VEC-1:0] shv = rd_src >> idx;
    assign bus_rdata[i] = ok && shv[0];
  end

  assign irq_enable  = en_q;
  assign irq_pending = pd_q;
  assign upd_strobe  = upd_q;

  assert_strobe_follows_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> $past(bus_we));

  assert_active_window_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && win_act) |=> ($stable(irq_enable) && $stable(irq_pending) && !upd_strobe));

  assert_idle_holds_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(irq_enable) && $stable(irq_pending) && !upd_strobe));

  assert_enable_write_keeps_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (win_es || win_ec)) |=> $stable(irq_pending));

  assert_pending_write_keeps_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (win_ps || win_pc)) |=> $stable(irq_enable));

  assert_trigger_pends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && trig_ix == 9'd0) |=> irq_pending[0]);
endmodule

// File: tb/tb_irq_state_bank.sv
module tb_irq_state_bank;
  localparam int NV = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [2:0]    bus_size = 3'd4;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NV-1:0] active_in = '0;
  logic [NV-1:0] irq_enable, irq_pending;
  logic          upd_strobe;

  int nchk = 0;
  int nfail = 0;

  irq_state_bank #(.NUM_VEC(NV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .active_in(active_in), .irq_enable(irq_enable), .irq_pending(irq_pending),
    .upd_strobe(upd_strobe)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, state and strobe visible at the following negedge
  task automatic wr(logic [11:0] a, logic [31:0] d, logic [2:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 enable", 64'(irq_enable), 64'h0);
    check("R1 pending", 64'(irq_pending), 64'h0);
    check("R1 strobe", 64'(upd_strobe), 64'h0);
    rd(12'h100, 3'd4, d);
    check("R1 read enable", 64'(d), 64'h0);
  endtask

  task automatic t_set_enable;
    wr(12'h100, 32'h5, 3'd4);
    check("R2 set enable", 64'(irq_enable), 64'h5);
    check("R11 strobe after set", 64'(upd_strobe), 64'h1);
    @(negedge clk);
    check("R11 strobe single cycle", 64'(upd_strobe), 64'h0);
    wr(12'h100, 32'h2, 3'd4);
    check("R2 zeros hold", 64'(irq_enable), 64'h7);
  endtask

  task automatic t_alias;
    logic [31:0] a, b;
    rd(12'h100, 3'd4, a);
    rd(12'h180, 3'd4, b);
    check("R6 set alias read", 64'(a), 64'h7);
    check("R6 clear alias read", 64'(b), 64'h7);
    check("R11 no strobe on read", 64'(upd_strobe), 64'h0);
  endtask

  task automatic t_clear_enable;
    wr(12'h180, 32'h5, 3'd4);
    check("R4 clear enable", 64'(irq_enable), 64'h2);
    wr(12'h100, 32'h8000_0000, 3'd4);
    check("R4 set bit 31", 64'(irq_enable), 64'h8000_0002);
    wr(12'h180, 32'h8000_0000, 3'd4);
    check("R4 set then clear", 64'(irq_enable), 64'h2);
    check("R11 strobe after clear", 64'(upd_strobe), 64'h1);
  endtask

  task automatic t_mapping;
    logic [31:0] d;
    wr(12'h104, 32'h81, 3'd1);
    check("R3 byte map", 64'(irq_enable), 64'h81_0000_0002);
    rd(12'h104, 3'd4, d);
    check("R9 partial word read", 64'(d), 64'h81);
    wr(12'h104, 32'hFFFF_FFFF, 3'd4);
    check("R9 writes past end ignored", 64'(irq_enable), 64'hFF_0000_0002);
    rd(12'h104, 3'd4, d);
    check("R9 out of range reads 0", 64'(d), 64'hFF);
    rd(12'h108, 3'd4, d);
    check("R9 empty word reads 0", 64'(d), 64'h0);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    wr(12'h200, 32'hF0F0, 3'd2);
    check("R5 set pending half", 64'(irq_pending), 64'hF0F0);
    check("R5 enable untouched", 64'(irq_enable), 64'hFF_0000_0002);
    wr(12'h281, 32'h30, 3'd1);
    check("R3 R5 clear pending byte", 64'(irq_pending), 64'hC0F0);
    rd(12'h200, 3'd4, d);
    check("R6 pending set alias", 64'(d), 64'hC0F0);
    rd(12'h280, 3'd4, d);
    check("R6 pending clear alias", 64'(d), 64'hC0F0);
    rd(12'h200, 3'd1, d);
    check("R8 byte read", 64'(d), 64'hF0);
    wr(12'h200, 32'hFFFF_FF00, 3'd1);
    check("R8 upper write bits ignored", 64'(irq_pending), 64'hC0F0);
  endtask

  task automatic t_active;
    logic [31:0] d;
    active_in = 40'h12_3456_789A;
    rd(12'h300, 3'd4, d);
    check("R7 active word 0", 64'(d), 64'h3456_789A);
    rd(12'h304, 3'd4, d);
    check("R7 R9 active word 1", 64'(d), 64'h12);
    wr(12'h300, 32'hFFFF_FFFF, 3'd4);
    check("R7 write ignored enable", 64'(irq_enable), 64'hFF_0000_0002);
    check("R7 write ignored pending", 64'(irq_pending), 64'hC0F0);
    check("R7 R11 no strobe", 64'(upd_strobe), 64'h0);
  endtask

  task automatic t_trigger;
    wr(12'hF00, 32'd0, 3'd4);
    check("R10 trigger index 0", 64'(irq_pending), 64'hC0F1);
    check("R11 strobe on trigger", 64'(upd_strobe), 64'h1);
    wr(12'hF00, 32'd40, 3'd4);
    check("R10 out of range index", 64'(irq_pending), 64'hC0F1);
    check("R11 no strobe out of range", 64'(upd_strobe), 64'h0);
    wr(12'hF00, 32'h227, 3'd4);
    check("R10 low nine bits", 64'(irq_pending), 64'h80_0000_C0F1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_enable();
    t_alias();
    t_clear_enable();
    t_mapping();
    t_pending();
    t_active();
    t_trigger();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule